// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers a small set of fast-class request lines, a larger set of normal-class request lines and one software break request. It presents a single winner to the processor as a valid flag, a class flag and a vector number. Each source has an enable bit and a pending bit. A pending bit is captured when the source's request rises. Software clears it by writing ones, and the processor clears it by accepting the interrupt.

The controller also tracks how deeply the processor is nested, and it forwards only the preemptions that the two-level scheme allows. A fast request may interrupt normal service. Nothing interrupts fast service. A normal request never interrupts another normal one. Each return strobe pops one level of the nesting state.

A separate wake output tells the sleep controller that some enabled source is pending. This output does not depend on the nesting state.

Top module: `nest_intc`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0, the nesting state is idle, and `int_valid` and `wake` are 0.
- R2: The `pend` vector is laid out as fast sources 0..2 in bits 2:0, normal sources 0..7 in bits 10:3, and the break source in bit 11. A rising request sets its bit on the clock edge at which it is first seen high. A request held high sets the bit only once, so after a clear the bit stays 0 while the request is held.
- R3: When `clr_wr` is high, each 1 in `clr_data` clears that pending bit and each 0 leaves it unchanged. If a rising request and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A pending source whose enable bit is 0 is never forwarded, but it stays pending. Enable bits use the same layout as `pend` and are all loaded when `en_wr` is high.
- R5: The fast class always beats the normal class. Within a class, the lowest-numbered pending enabled source wins. `int_fast` is 1 for a fast winner and 0 for a normal winner, and `int_vec` is the source number within its class.
- R6: `ack` while `int_valid` is high clears the winner's pending bit and enters the matching service level. While normal service is active, only fast requests are forwarded.
- R7: While fast service is active, whether entered from idle or over normal service, no request is forwarded.
- R8: `reti` pops one level: fast-over-normal goes back to normal service, and fast or normal service goes back to idle. `reti` while idle changes nothing. When `reti` and `ack` arrive in the same cycle, `reti` is taken and `ack` is ignored, so the pending bit is kept.
- R9: The break request joins the normal class as vector 8. This is the lowest priority in that class.
- R10: `wake` is 1 exactly when some source is both pending and enabled, in every nesting state.
- R11: `ack` while `int_valid` is 0 changes neither the nesting state nor any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_req | input | 3 | Fast-class request lines |
| norm_req | input | 8 | Normal-class request lines |
| brk_req | input | 1 | Software break request |
| en_wr | input | 1 | Load the enable register |
| en_wdata | input | 12 | New enable bits |
| clr_wr | input | 1 | Write-one-to-clear strobe for pending bits |
| clr_data | input | 12 | Pending bits to clear |
| ack | input | 1 | Processor accepts the presented interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| int_valid | output | 1 | An interrupt is presented |
| int_fast | output | 1 | Class of the presented interrupt (1 = fast) |
| int_vec | output | 4 | Vector number within the class |
| pend | output | 12 | Pending register |
| wake | output | 1 | Wake request to the sleep controller |

## Verification
The bench drives a full nesting sequence: normal service, a fast preemption, a second fast pending during nested service, and the pops back down. A controller that let one normal request preempt another, or that popped fast-over-normal straight to idle, would present a vector where the bench expects none. The bench also drives a clear and a rising edge into the same cycle, holds a request level across a clear, and issues `ack` together with `reti`. A design that gave the clear priority, re-triggered on a held level, or honoured the simultaneous `ack` would leave a wrong pending bit. Finally, the bench issues a stray `ack` with nothing presented. A design that changed state on it would block the next normal request.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        NS_IDLE      = 2'd0,
        NS_NORM      = 2'd1,
        NS_FAST_NEST = 2'd2,
        NS_FAST      = 2'd3
    } nest_e;
endpackage

// File: rtl/nic_src_bank.sv
module nic_src_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_data,
    input  logic [W-1:0] take,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] en_q
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] pend;
        logic [W-1:0] en;
    } bank_t;

    bank_t r_d, r_q;
    logic [W-1:0] rise;
    logic [W-1:0] wipe;

    always_comb begin
        r_d      = r_q;
        rise     = req & ~r_q.prev;
        wipe     = (clr_wr ? clr_data : '0) | take;
        r_d.prev = req;
        r_d.pend = (r_q.pend & ~wipe) | rise;
        if (en_wr) r_d.en = en_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pend_q = r_q.pend;
    assign en_q   = r_q.en;

    for (genvar i = 0; i < W; i++) begin : g_chk
        a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req[i]) |=> pend_q[i]);
        a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_data[i] && !req[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/nic_pick.sv
module nic_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/nic_nest.sv
module nic_nest
    import nic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take_fast,
    input  logic  take_norm,
    input  logic  reti,
    output nest_e state
);
    typedef struct packed {
        nest_e st;
    } nest_t;

    nest_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reti) begin
            case (s_q.st)
                NS_FAST_NEST: s_d.st = NS_NORM;
                NS_FAST:      s_d.st = NS_IDLE;
                NS_NORM:      s_d.st = NS_IDLE;
                default:      s_d.st = NS_IDLE;
            endcase
        end else if (take_fast) begin
            s_d.st = (s_q.st == NS_NORM) ? NS_FAST_NEST : NS_FAST;
        end else if (take_norm) begin
            s_d.st = NS_NORM;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: NS_IDLE};
        else        s_q <= s_d;
    end

    assign state = s_q.st;

    a_r8_pop_to_norm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_FAST_NEST && reti) |=> state == NS_NORM);
    a_r7_fast_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_FAST && !reti) |=> state == NS_FAST);
    a_r8_idle_reti: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_IDLE && reti) |=> state == NS_IDLE);
endmodule

// File: rtl/nest_intc.sv
module nest_intc
    import nic_pkg::*;
#(
    parameter int N_FAST = 3,
    parameter int N_NORM = 8,
    localparam int NORM_W  = N_NORM + 1,
    localparam int N_SRC   = N_FAST + NORM_W,
    localparam int SPAN    = (N_FAST > NORM_W) ? N_FAST : NORM_W,
    localparam int VEC_W   = (SPAN > 1) ? $clog2(SPAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FAST-1:0] fast_req,
    input  logic [N_NORM-1:0] norm_req,
    input  logic              brk_req,
    input  logic              en_wr,
    input  logic [N_SRC-1:0]  en_wdata,
    input  logic              clr_wr,
    input  logic [N_SRC-1:0]  clr_data,
    input  logic              ack,
    input  logic              reti,
    output logic              int_valid,
    output logic              int_fast,
    output logic [VEC_W-1:0]  int_vec,
    output logic [N_SRC-1:0]  pend,
    output logic              wake
);
    localparam int FAST_IW = (N_FAST > 1) ? $clog2(N_FAST) : 1;
    localparam int NORM_IW = (NORM_W > 1) ? $clog2(NORM_W) : 1;

    logic [N_SRC-1:0]   req_all, en_q, act, take;
    logic [N_FAST-1:0]  fast_act;
    logic [NORM_W-1:0]  norm_act;
    logic               fast_found, norm_found;
    logic [FAST_IW-1:0] fast_idx;
    logic [NORM_IW-1:0] norm_idx;
    logic               sel_fast, sel_norm, accept;
    nest_e              state;

    assign req_all = {brk_req, norm_req, fast_req};

    nic_src_bank #(.W(N_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .req(req_all),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .clr_wr(clr_wr), .clr_data(clr_data),
        .take(take), .pend_q(pend), .en_q(en_q)
    );

    assign act      = pend & en_q;
    assign fast_act = act[N_FAST-1:0];
    assign norm_act = act[N_SRC-1:N_FAST];

    nic_pick #(.W(N_FAST), .IW(FAST_IW)) u_pick_fast (
        .vec(fast_act), .found(fast_found), .idx(fast_idx)
    );
    nic_pick #(.W(NORM_W), .IW(NORM_IW)) u_pick_norm (
        .vec(norm_act), .found(norm_found), .idx(norm_idx)
    );

    always_comb begin
        sel_fast  = fast_found && (state == NS_IDLE || state == NS_NORM);
        sel_norm  = !sel_fast && norm_found && (state == NS_IDLE);
        int_valid = sel_fast || sel_norm;
        int_fast  = sel_fast;
        int_vec   = sel_fast ? VEC_W'(fast_idx) : VEC_W'(norm_idx);
        accept    = ack && int_valid && !reti;
        take      = '0;
        if (accept && sel_fast)      take[int'(fast_idx)] = 1'b1;
        else if (accept && sel_norm) take[N_FAST + int'(norm_idx)] = 1'b1;
    end

    nic_nest u_nest (
        .clk(clk), .rst_n(rst_n),
        .take_fast(accept && sel_fast),
        .take_norm(accept && sel_norm),
        .reti(reti), .state(state)
    );

    assign wake = |act;

    a_r7_fast_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_FAST || state == NS_FAST_NEST) |-> !int_valid);
    a_r6_norm_only_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (state == NS_NORM && int_valid) |-> int_fast);
    a_r5_fast_first: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && !int_fast) |-> !(|fast_act));
    a_r10_wake_any: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> wake);
    a_r11_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_valid && !reti) |=> $stable(state));
endmodule

// File: tb/sim_nest_intc.sv
module sim_nest_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] req_b = '0;
    logic        en_wr = 1'b0, clr_wr = 1'b0, ack = 1'b0, reti = 1'b0;
    logic [11:0] en_wdata = '0, clr_data = '0;
    logic        int_valid, int_fast, wake;
    logic [3:0]  int_vec;
    logic [11:0] pend;
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    nest_intc u0 (
        .clk(clk), .rst_n(rst_n),
        .fast_req(req_b[2:0]), .norm_req(req_b[10:3]), .brk_req(req_b[11]),
        .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_data(clr_data),
        .ack(ack), .reti(reti), .int_valid(int_valid), .int_fast(int_fast),
        .int_vec(int_vec), .pend(pend), .wake(wake)
    );

    // {en[11:0], req[11:0], valid, fast, vec[3:0]}
    localparam logic [29:0] TAB [8] = '{
        {12'hFFF, 12'h00A, 1'b1, 1'b1, 4'd1},
        {12'hFFF, 12'h120, 1'b1, 1'b0, 4'd2},
        {12'h000, 12'h001, 1'b0, 1'b0, 4'd0},
        {12'hFF8, 12'h401, 1'b1, 1'b0, 4'd7},
        {12'hFFF, 12'hA00, 1'b1, 1'b0, 4'd6},
        {12'hFFF, 12'h800, 1'b1, 1'b0, 4'd8},
        {12'hFFF, 12'h006, 1'b1, 1'b1, 4'd1},
        {12'h7FF, 12'h800, 1'b0, 1'b0, 4'd0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [11:0] b);
        req_b = b; step(); req_b = '0;
    endtask

    task automatic clr(input logic [11:0] b);
        clr_wr = 1'b1; clr_data = b; step(); clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic wen(input logic [11:0] b);
        en_wr = 1'b1; en_wdata = b; step(); en_wr = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic v, input logic f, input logic [3:0] vec);
        chk({tag, " valid"}, 16'(int_valid), 16'(v));
        if (v) begin
            chk({tag, " class"}, 16'(int_fast), 16'(f));
            chk({tag, " vector"}, 16'(int_vec), 16'(vec));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 pend", 16'(pend), 16'h0);
        chk("R1 valid", 16'(int_valid), 16'h0);
        chk("R1 wake", 16'(wake), 16'h0);
        pulse(12'h001);
        chk("R1 enables cleared", 16'(int_valid), 16'h0);
        clr(12'hFFF);

        // table: R2 R4 R5 R9 R10
        for (int i = 0; i < 8; i++) begin
            wen(TAB[i][29:18]);
            pulse(TAB[i][17:6]);
            chk("R2 pend capture", 16'(pend), 16'(TAB[i][17:6]));
            chk("R10 wake", 16'(wake), 16'(|(TAB[i][29:18] & TAB[i][17:6])));
            expect_out("R5 table", TAB[i][5], TAB[i][4], TAB[i][3:0]);
            clr(12'hFFF);
        end

        // R4 enabling a waiting source forwards it
        wen(12'h000);
        pulse(12'h010);
        expect_out("R4 disabled", 1'b0, 1'b0, 4'd0);
        wen(12'hFFF);
        expect_out("R4 enabled later", 1'b1, 1'b0, 4'd1);
        clr(12'hFFF);

        // R2 held level does not re-set after clear
        req_b = 12'h008; step();
        chk("R2 held set", 16'(pend[3]), 16'h1);
        clr_wr = 1'b1; clr_data = 12'h008; step(); clr_wr = 1'b0;
        chk("R2 held cleared", 16'(pend[3]), 16'h0);
        step();
        chk("R2 held no reset", 16'(pend[3]), 16'h0);
        req_b = '0; step();

        // R3 partial clear and set-wins
        pulse(12'h0C0);
        clr(12'h040);
        chk("R3 w1c partial", 16'(pend), 16'h080);
        req_b = 12'h001; clr_wr = 1'b1; clr_data = 12'h001; step();
        req_b = '0; clr_wr = 1'b0;
        chk("R3 set wins", 16'(pend[0]), 16'h1);
        clr(12'hFFF);

        // nesting R6 R7 R8 R10
        pulse(12'h040);                               // norm 3
        expect_out("R6 norm present", 1'b1, 1'b0, 4'd3);
        do_ack();
        chk("R6 ack clears", 16'(pend), 16'h0);
        pulse(12'h010);                               // norm 1 during norm service
        expect_out("R6 norm blocks norm", 1'b0, 1'b0, 4'd0);
        chk("R10 wake in service", 16'(wake), 16'h1);
        pulse(12'h004);                               // fast 2
        expect_out("R6 fast preempts", 1'b1, 1'b1, 4'd2);
        do_ack();
        expect_out("R7 nested blocks", 1'b0, 1'b0, 4'd0);
        pulse(12'h001);                               // fast 0
        expect_out("R7 nested blocks fast", 1'b0, 1'b0, 4'd0);
        chk("R10 wake nested", 16'(wake), 16'h1);
        do_reti();
        expect_out("R8 pop to norm", 1'b1, 1'b1, 4'd0);
        do_ack();
        do_reti();
        expect_out("R8 back in norm", 1'b0, 1'b0, 4'd0);
        do_reti();
        expect_out("R8 back idle", 1'b1, 1'b0, 4'd1);
        do_reti();
        expect_out("R8 reti idle", 1'b1, 1'b0, 4'd1);
        ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
        chk("R8 ack with reti ignored", 16'(pend), 16'h010);
        expect_out("R8 still idle", 1'b1, 1'b0, 4'd1);
        do_ack();
        do_reti();
        expect_out("R8 empty", 1'b0, 1'b0, 4'd0);

        // R11 stray ack
        do_ack();
        pulse(12'h008);
        expect_out("R11 stray ack", 1'b1, 1'b0, 4'd0);
        chk("R11 pend kept", 16'(pend), 16'h008);
        clr(12'hFFF);

        // R7 fast from idle
        pulse(12'h002);
        do_ack();
        pulse(12'h020);
        expect_out("R7 fast blocks norm", 1'b0, 1'b0, 4'd0);
        do_reti();
        expect_out("R8 fast pop idle", 1'b1, 1'b0, 4'd2);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule